// File: doc/BRIEF.md
# Indexed and Relative Address Generator

This block works out the effective address of an instruction's operand for an 8-bit processor with a 16-bit address space. The sequencer pulses `start` on the opcode byte and supplies the addressing mode, the current index register value and the address of the opcode. The block then reads the operand bytes that follow the opcode through a byte-wide fetch port, one byte per cycle. After that it reports the effective address, the instruction length in bytes and the address of the following opcode.

Five modes are supported. Three are indexed forms: the index alone, the index plus one unsigned byte, and the index plus an unsigned 16-bit word. The other two are page-zero direct and PC-relative branch. The fetch port is combinational: the byte at `fetch_addr` must be present on `fetch_data` in the same cycle that `fetch_req` is high, and the block captures it at the closing clock edge. Results are valid while `done` is high. They stay stable until the next accepted `start`.

Top module: `addr_gen_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `fetch_req` and `done` are all low.
- R2: Mode code 0 (index only): `ea_out` = {0x00, index}, `len_out` = 1, no fetch is issued, and `done` is high in the cycle right after the one in which `start` was accepted.
- R3: Mode code 1 (index + byte): exactly one fetch at opcode address + 1. `ea_out` = index + byte, both taken unsigned and added to 9 bits without truncation, so the highest possible result is 0x01FE. `len_out` = 2.
- R4: Mode code 2 (index + word): two fetches in consecutive cycles, the high byte at opcode address + 1 and the low byte at opcode address + 2. `ea_out` = {high, low} + index modulo 65536, and `len_out` = 3.
- R5: Mode code 3 (direct): one fetch at opcode address + 1, `ea_out` = {0x00, byte}, `len_out` = 2.
- R6: Mode code 4 (relative): one fetch at opcode address + 1. `ea_out` = (opcode address + 2) + the byte sign-extended to 16 bits (0x80 = -128, 0x7F = +127), modulo 65536. `len_out` = 2.
- R7: `next_pc` = opcode address + `len_out` modulo 65536 in every mode. Fetch addresses also wrap modulo 65536.
- R8: Fetches start in the cycle after acceptance, one per operand byte, in consecutive cycles. `done` is a single-cycle pulse in the cycle after the last fetch, and `busy` is high from the first cycle after acceptance through the `done` cycle. The block is otherwise quiet.
- R9: `start` is accepted only when `busy` is low. A `start` seen while busy, including in the `done` cycle, has no effect on the fetch sequence or on the results.
- R10: The unused mode codes 5, 6 and 7 behave exactly like mode code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin address generation (accepted when idle) |
| mode_in | input | 3 | Addressing mode code |
| index_in | input | DATA_W | Index register value |
| pc_in | input | ADDR_W | Address of the opcode byte |
| fetch_req | output | 1 | Operand byte read request |
| fetch_addr | output | ADDR_W | Operand byte address |
| fetch_data | input | DATA_W | Operand byte, valid in the request cycle |
| busy | output | 1 | Generation in progress (including done cycle) |
| done | output | 1 | Results valid pulse |
| ea_out | output | ADDR_W | Effective address |
| len_out | output | 2 | Instruction length in bytes |
| next_pc | output | ADDR_W | Address of the following opcode |

## Verification
The bench drives index values 0x00 and 0xFF against offset bytes 0x00 and 0xFF. A design that truncates the byte-offset sum to 8 bits would report 0x00FE instead of 0x01FE. A design that sign-extends the index would be off by 0xFF00. Branch offsets 0x80 and 0x7F are run at opcode addresses near 0x0000 and 0xFFFF, which exposes a target taken from the branch's own address (off by two) and a missing or unsigned extension. Word offsets are fetched across the 0xFFFF boundary to catch a swapped byte order or a fetch address that fails to wrap. `start` is held high during busy periods, so a design that re-accepts in the done cycle shows a fetch or a `done` one cycle too early.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;

  typedef enum logic [2:0] {
    AM_IDX0 = 3'd0,
    AM_IDX1 = 3'd1,
    AM_IDX2 = 3'd2,
    AM_DIR  = 3'd3,
    AM_REL  = 3'd4
  } am_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_DONE  = 2'd2
  } sq_state_e;

  // Unused codes fold onto index-only mode.
  function automatic am_mode_e am_decode(input logic [2:0] code);
    am_mode_e m;
    case (code)
      3'd1:    m = AM_IDX1;
      3'd2:    m = AM_IDX2;
      3'd3:    m = AM_DIR;
      3'd4:    m = AM_REL;
      default: m = AM_IDX0;
    endcase
    return m;
  endfunction

  function automatic logic [1:0] am_operand_bytes(input am_mode_e m);
    logic [1:0] n;
    case (m)
      AM_IDX0: n = 2'd0;
      AM_IDX2: n = 2'd2;
      default: n = 2'd1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/addr_gen_seq.sv
module addr_gen_seq
  import addr_gen_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode_in,
  input  logic [DATA_W-1:0] index_in,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              busy,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              done,
  output logic              op_clr,
  output logic              op_shift,
  output am_mode_e          mode_q,
  output logic [DATA_W-1:0] index_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [1:0]        len_q
);

  sq_state_e   state_q, state_d;
  logic [1:0]  left_q, left_d;
  logic [1:0]  off_q, off_d;
  logic        latch_en;
  am_mode_e    mode_dec;
  logic [1:0]  nbytes;

  assign mode_dec = am_decode(mode_in);
  assign nbytes   = am_operand_bytes(mode_dec);

  always_comb begin
    state_d  = state_q;
    left_d   = left_q;
    off_d    = off_q;
    latch_en = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          latch_en = 1'b1;
          left_d   = nbytes;
          off_d    = 2'd1;
          state_d  = (nbytes == 2'd0) ? SQ_DONE : SQ_FETCH;
        end
      end
      SQ_FETCH: begin
        if (left_q == 2'd1) begin
          state_d = SQ_DONE;
        end else begin
          left_d = left_q - 2'd1;
          off_d  = off_q + 2'd1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      left_q  <= '0;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      off_q   <= off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= AM_IDX0;
      index_q <= '0;
      pc_q    <= '0;
      len_q   <= '0;
    end else if (latch_en) begin
      mode_q  <= mode_dec;
      index_q <= index_in;
      pc_q    <= pc_in;
      len_q   <= nbytes + 2'd1;
    end
  end

  assign busy       = (state_q != SQ_IDLE);
  assign fetch_req  = (state_q == SQ_FETCH);
  assign done       = (state_q == SQ_DONE);
  assign fetch_addr = pc_q + ADDR_W'(off_q);
  assign op_clr     = latch_en;
  assign op_shift   = fetch_req;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && $past(fetch_req)) |-> (fetch_addr == $past(fetch_addr) + ADDR_W'(1))); // R4

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(pc_q) && $stable(mode_q) && $stable(index_q))); // R9

endmodule

// File: rtl/addr_gen_operand.sv
module addr_gen_operand #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     shift,
  input  logic [DATA_W-1:0]        din,
  output logic [NBYTES*DATA_W-1:0] op_q
);

  localparam int OP_W = NBYTES * DATA_W;

  logic [OP_W-1:0] op_d;

  generate
    if (NBYTES > 1) begin : g_multi
      always_comb begin
        op_d = op_q;
        if (clr)        op_d = '0;
        else if (shift) op_d = {op_q[OP_W-DATA_W-1:0], din};
      end
    end else begin : g_single
      always_comb begin
        op_d = op_q;
        if (clr)        op_d = '0;
        else if (shift) op_d = din;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= '0;
    else        op_q <= op_d;
  end

endmodule

// File: rtl/addr_gen_calc.sv
module addr_gen_calc
  import addr_gen_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  am_mode_e          mode,
  input  logic [DATA_W-1:0] index,
  input  logic [ADDR_W-1:0] operand,
  input  logic [ADDR_W-1:0] pc,
  input  logic [1:0]        len,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] next_pc
);

  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] low_ext;
  logic [ADDR_W-1:0] rel_ext;

  assign idx_ext = {{EXT_W{1'b0}}, index};
  assign low_ext = {{EXT_W{1'b0}}, operand[DATA_W-1:0]};
  assign rel_ext = {{EXT_W{operand[DATA_W-1]}}, operand[DATA_W-1:0]};
  assign next_pc = pc + ADDR_W'(len);

  always_comb begin
    case (mode)
      AM_IDX1: ea = idx_ext + low_ext;
      AM_IDX2: ea = operand + idx_ext;
      AM_DIR:  ea = low_ext;
      AM_REL:  ea = next_pc + rel_ext;
      default: ea = idx_ext;
    endcase
  end

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import addr_gen_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode_in,
  input  logic [DATA_W-1:0] index_in,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] fetch_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ea_out,
  output logic [1:0]        len_out,
  output logic [ADDR_W-1:0] next_pc
);

  localparam int OP_BYTES = ADDR_W / DATA_W;

  am_mode_e          mode_q;
  logic [DATA_W-1:0] index_q;
  logic [ADDR_W-1:0] pc_q;
  logic [1:0]        len_q;
  logic              op_clr;
  logic              op_shift;
  logic [ADDR_W-1:0] operand_q;

  addr_gen_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_in    (mode_in),
    .index_in   (index_in),
    .pc_in      (pc_in),
    .busy       (busy),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .done       (done),
    .op_clr     (op_clr),
    .op_shift   (op_shift),
    .mode_q     (mode_q),
    .index_q    (index_q),
    .pc_q       (pc_q),
    .len_q      (len_q)
  );

  addr_gen_operand #(.DATA_W(DATA_W), .NBYTES(OP_BYTES)) opnd_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (op_clr),
    .shift (op_shift),
    .din   (fetch_data),
    .op_q  (operand_q)
  );

  addr_gen_calc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) calc_i (
    .mode    (mode_q),
    .index   (index_q),
    .operand (operand_q),
    .pc      (pc_q),
    .len     (len_q),
    .ea      (ea_out),
    .next_pc (next_pc)
  );

  assign len_out = len_q;

  // Fetch counter used only by the checks below.
  logic [1:0] chk_fetches;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                chk_fetches <= '0;
    else if (start && !busy)   chk_fetches <= '0;
    else if (fetch_req)        chk_fetches <= chk_fetches + 2'd1;
  end

  AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (len_out == chk_fetches + 2'd1)); // R8

  AST_IDX1_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == AM_IDX1) |-> (ea_out <= ADDR_W'(2 * ((1 << DATA_W) - 1)))); // R3

  AST_IDX0_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && len_out == 2'd1) |-> (ea_out[ADDR_W-1:DATA_W] == '0)); // R2

  AST_NO_FETCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !fetch_req); // R8

endmodule

// File: tb/addr_gen_unit_tb.sv
`timescale 1ns/1ps
module addr_gen_unit_tb_top;

  typedef struct packed {
    logic [1:0]  kind;   // 0 idle, 1 fetch, 2 done
    logic [15:0] addr;
    logic [15:0] ea;
    logic [1:0]  len;
    logic [15:0] npc;
  } exp_rec_t;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  mode_in;
  logic [7:0]  index_in;
  logic [15:0] pc_in;
  logic        fetch_req;
  logic [15:0] fetch_addr;
  logic [7:0]  fetch_data;
  logic        busy;
  logic        done;
  logic [15:0] ea_out;
  logic [1:0]  len_out;
  logic [15:0] next_pc;

  logic [15:0] ov_a1, ov_a2;
  logic [7:0]  ov_b1, ov_b2;

  int checks = 0;
  int errors = 0;

  exp_rec_t eq[$];
  string    tq[$];

  addr_gen_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_in),
    .index_in(index_in), .pc_in(pc_in), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_data(fetch_data), .busy(busy),
    .done(done), .ea_out(ea_out), .len_out(len_out), .next_pc(next_pc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    if (a == ov_a1) return ov_b1;
    if (a == ov_a2) return ov_b2;
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign fetch_data = (fetch_addr == ov_a1) ? ov_b1 :
                      (fetch_addr == ov_a2) ? ov_b2 :
                      (fetch_addr[7:0] ^ fetch_addr[15:8] ^ 8'h3C);

  function automatic string tag_of(input int m);
    case (m)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      0: return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic push_expect(input int m, input int idx, input int pc, input string t);
    int b1, b2, ln, ea, npc, off;
    exp_rec_t r;
    b1 = mem_byte(16'((pc + 1) & 16'hFFFF));
    b2 = mem_byte(16'((pc + 2) & 16'hFFFF));
    ln = (m == 2) ? 3 : ((m == 1 || m == 3 || m == 4) ? 2 : 1);
    npc = (pc + ln) & 16'hFFFF;
    case (m)
      1: ea = idx + b1;
      2: ea = (b1 * 256 + b2 + idx) & 16'hFFFF;
      3: ea = b1;
      4: begin off = (b1 > 127) ? b1 - 256 : b1; ea = (pc + 2 + off) & 16'hFFFF; end
      default: ea = idx;
    endcase
    for (int k = 1; k < ln; k++) begin
      r = '0; r.kind = 2'd1; r.addr = 16'((pc + k) & 16'hFFFF);
      eq.push_back(r); tq.push_back(t);
    end
    r = '0; r.kind = 2'd2; r.ea = 16'(ea); r.len = 2'(ln); r.npc = 16'(npc);
    eq.push_back(r); tq.push_back((m <= 4) ? t : "R10");
  endtask

  // Compare this cycle, then drive the inputs for the next edge.
  task automatic step(input logic st, input int m, input int idx, input int pc, input string t);
    exp_rec_t r;
    string    ct;
    bit       bad;
    bit       idle;
    if (eq.size() > 0) begin
      r = eq.pop_front(); ct = tq.pop_front(); idle = 1'b0;
    end else begin
      r = '0; ct = "R8"; idle = 1'b1;
    end
    bad = (busy !== (r.kind != 2'd0)) || (fetch_req !== (r.kind == 2'd1)) ||
          (done !== (r.kind == 2'd2));
    if (r.kind == 2'd1 && fetch_addr !== r.addr) bad = 1'b1;
    if (r.kind == 2'd2 && (ea_out !== r.ea || len_out !== r.len || next_pc !== r.npc)) bad = 1'b1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: act busy=%b req=%b addr=%h done=%b ea=%h len=%0d npc=%h | exp kind=%0d addr=%h ea=%h len=%0d npc=%h",
               ct, busy, fetch_req, fetch_addr, done, ea_out, len_out, next_pc,
               r.kind, r.addr, r.ea, r.len, r.npc);
    end
    if (st && idle) push_expect(m, idx, pc, t);
    start    = st;
    mode_in  = 3'(m);
    index_in = 8'(idx);
    pc_in    = 16'(pc);
    @(negedge clk);
  endtask

  task automatic run_instr(input int m, input int idx, input int pc, input int b1, input int b2);
    ov_a1 = 16'((pc + 1) & 16'hFFFF); ov_b1 = 8'(b1);
    ov_a2 = 16'((pc + 2) & 16'hFFFF); ov_b2 = 8'(b2);
    step(1'b1, m, idx, pc, tag_of(m));
    for (int g = 0; g < 6 && eq.size() > 0; g++) step(1'b0, 0, 0, 0, "R8");
    step(1'b0, 0, 0, 0, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lf;
    rst_n = 1'b0; start = 1'b0; mode_in = '0; index_in = '0; pc_in = '0;
    ov_a1 = 16'h0001; ov_a2 = 16'h0002; ov_b1 = '0; ov_b2 = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || fetch_req !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1: act busy=%b req=%b done=%b exp 0 0 0", busy, fetch_req, done);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 0, 0, 0, "R1");

    // R2 index only
    run_instr(0, 8'h00, 16'h1234, 0, 0);
    run_instr(0, 8'hFF, 16'hFFFF, 0, 0);
    // R3 index + byte, corner grid
    for (int i = 0; i < 2; i++)
      for (int o = 0; o < 2; o++)
        run_instr(1, i * 255, 16'h0400, o * 255, 8'h11);
    // R4 index + word, includes wrap of fetch address and sum (R7)
    run_instr(2, 8'h00, 16'h2000, 8'h00, 8'h00);
    run_instr(2, 8'hFF, 16'h2000, 8'hFF, 8'hFF);
    run_instr(2, 8'hFF, 16'hFFFE, 8'h00, 8'hFF);
    run_instr(2, 8'h01, 16'hFFFF, 8'hAB, 8'hCD);
    run_instr(2, 8'h00, 16'h3000, 8'hFF, 8'h00);
    // R5 direct
    run_instr(3, 8'hFF, 16'h0100, 8'h00, 0);
    run_instr(3, 8'h00, 16'h0100, 8'hFF, 0);
    // R6 relative, both extremes, near both ends of memory
    run_instr(4, 0, 16'h8000, 8'h80, 0);
    run_instr(4, 0, 16'h8000, 8'h7F, 0);
    run_instr(4, 0, 16'h0010, 8'h80, 0);
    run_instr(4, 0, 16'hFFF0, 8'h7F, 0);
    run_instr(4, 0, 16'hFFFE, 8'h00, 0);
    // R10 unused codes
    for (int c = 5; c < 8; c++) run_instr(c, 8'hA5, 16'h5555, 8'h77, 8'h66);
    // R9 start held high while busy, mode changing every cycle
    ov_a1 = 16'h6001; ov_b1 = 8'h12; ov_a2 = 16'h6002; ov_b2 = 8'h34;
    for (int n = 0; n < 12; n++) step(1'b1, (n % 2) ? 2 : 1, 8'h10 + n, 16'h6000, "R9");
    for (int n = 0; n < 5; n++) step(1'b0, 0, 0, 0, "R9");
    // Mixed patterns (R7)
    lf = 16'hACE1;
    for (int n = 0; n < 40; n++) begin
      lf = ((lf >> 1) ^ ((lf & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      run_instr(lf % 5, (lf >> 3) & 8'hFF, (lf * 7) & 16'hFFFF, (lf >> 5) & 8'hFF, lf & 8'hFF);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule